// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A 16-bit free-running up-counter shared by four independent channels. Each channel is set up either to record the counter value when a chosen transition arrives on its input pin (capture) or to raise an event and toggle its output pin when the counter reaches a programmed value (compare). The counter sets an overflow flag whenever it wraps. Each channel has its own event flag. A single interrupt line combines every flag with its enable bit.

Software reaches the block over an 8-bit register bus with separate read and write strobes. Read data is registered and appears one clock after the read strobe. A 16-bit value is moved as two bytes, high byte first. A high-byte read freezes the low byte for the read that follows. A high-byte write is held until the low-byte write commits both halves in one step. An optional fast-clear mode lets any access to the counter bytes acknowledge the overflow flag, so no separate flag write is needed.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register reads 0x00, `cmp_o` is all zeros and `irq_o` is low. Register map: 0x0 control (bit0 run, bit1 fast clear), 0x1 mode (bit n is channel n), 0x2 edge select (bits 2n+1:2n for channel n), 0x3 interrupt enable (bit n is channel n, bit7 is overflow), 0x4 flags (bit n is channel n, bit7 is overflow), 0x6/0x7 counter high/low, 0x8+2n/0x9+2n channel n high/low.
- R2: The counter adds one on each clock while the run bit is 1 and holds its value while the run bit is 0. Writing the high byte and then the low byte loads the counter.
- R3: The overflow flag sets when a counting step takes the counter from 0xFFFF to 0x0000. A step that ends on 0xFFFF does not set it.
- R4: Writing 1 to a bit of the flags register clears that flag. Writing 0 leaves it unchanged. A flag that is set and cleared in the same cycle ends up set.
- R5: While the fast-clear bit is 1, any read or write of address 0x6 or 0x7 clears the overflow flag. While the fast-clear bit is 0, such accesses leave the flag unchanged.
- R6: Mode bit n set to 0 makes channel n a capture channel. Set to 1, it makes channel n a compare channel, and channel-register writes are accepted.
- R7: A capture channel's input passes through a two-flop synchronizer. The edge code selects the transition: 00 none, 01 rising, 10 falling, 11 both. On a selected transition the channel register takes the current counter value and the channel flag sets.
- R8: Writes to a channel register are ignored while that channel is in capture mode.
- R9: A compare channel whose register equals the counter on a counting clock sets its flag and toggles its `cmp_o` bit.
- R10: Reading a high byte latches the matching low byte, and the next low-byte read returns that latched value. A high-byte write alone changes nothing; the low-byte write commits the held high byte together with the new low byte.
- R11: `irq_o` is high exactly when some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one clock after the read strobe |
| cap_i | input | NUM_CH | Channel input pins |
| cmp_o | output | NUM_CH | Channel output pins |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound assertions check, on every cycle, the per-clock properties of the block. These are counting steps and holds, the wrap setting the overflow flag, fast-clear acknowledgement, capture loading the counter value and the flag, capture-mode writes leaving the channel register untouched, and a compare hit toggling the pin. What they cannot show is the bus-visible result of whole sequences. The bench sweeps every channel against every edge code with both transition directions. It also reads back counter runs of several lengths, tests the wrap boundary on each side, covers flag clearing with ones and zeros, and checks fast clear both on and off. Finally it checks the ordered byte access and the gating of the interrupt line by each enable.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
  localparam logic [ADDR_W-1:0] A_MODE    = 4'h1;
  localparam logic [ADDR_W-1:0] A_EDGE    = 4'h2;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'h3;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'h6;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h7;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 4'h8;
endpackage

// File: rtl/capcmp_edge_det.sv
module capcmp_edge_det
  import capcmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  // [0],[1] synchronizer, [2] previous synchronized sample
  logic [2:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    case (edge_sel_e'(sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = run_i & ~load_i & (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         run_i,
  input  logic         cmp_mode_i,
  input  logic         cap_hit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic         cmp_hit_o,
  output logic         event_o,
  output logic         out_o
);
  logic [W-1:0] val_q;
  logic         out_q;
  logic         cap_ev;

  assign cap_ev    = ~cmp_mode_i & cap_hit_i;
  assign cmp_hit_o = cmp_mode_i & run_i & (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cap_ev)                   val_q <= cnt_i;
      else if (wr_i && cmp_mode_i)  val_q <= wdata_i;
      if (cmp_hit_o)                out_q <= ~out_q;
    end
  end

  assign val_o   = val_q;
  assign event_o = cap_ev | cmp_hit_o;
  assign out_o   = out_q;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] cap_i,
  output logic [NUM_CH-1:0] cmp_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned EDGE_W = 2 * NUM_CH;

  logic              run_q, fast_q, ovf_q, ien_ovf_q;
  logic [NUM_CH-1:0] mode_q, ien_ch_q, flag_ch_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] wr_hold_q, rd_hold_q, rdata_q;

  logic [CNT_W-1:0]  cnt;
  logic              wrap, cnt_load, cnt_access, hi_wr, wr_flags;
  logic [NUM_CH-1:0] cap_hit, cmp_hit, ch_event, ch_wr;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_val;

  logic [BYTE_W-1:0] rd_mux, rd_snap;
  logic              snap_en;

  // write decode
  assign cnt_load   = wr_en_i & (addr_i == A_CNT_LO);
  assign cnt_access = (wr_en_i | rd_en_i) & ((addr_i == A_CNT_HI) | (addr_i == A_CNT_LO));
  assign hi_wr      = wr_en_i & ((addr_i == A_CNT_HI) | (addr_i[3] & ~addr_i[0]));
  assign wr_flags   = wr_en_i & (addr_i == A_FLAGS);

  capcmp_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .load_i     (cnt_load),
    .load_val_i ({wr_hold_q, wdata_i}),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_wr[n] = wr_en_i & (addr_i == A_CH_BASE + ADDR_W'(2 * n + 1));

    capcmp_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[n]),
      .sel_i  (edge_q[2*n +: 2]),
      .hit_o  (cap_hit[n])
    );

    capcmp_channel #(.W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .run_i      (run_q),
      .cmp_mode_i (mode_q[n]),
      .cap_hit_i  (cap_hit[n]),
      .wr_i       (ch_wr[n]),
      .wdata_i    ({wr_hold_q, wdata_i}),
      .val_o      (ch_val[n]),
      .cmp_hit_o  (cmp_hit[n]),
      .event_o    (ch_event[n]),
      .out_o      (cmp_o[n])
    );
  end

  // control and configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      fast_q    <= 1'b0;
      mode_q    <= '0;
      edge_q    <= '0;
      ien_ch_q  <= '0;
      ien_ovf_q <= 1'b0;
      wr_hold_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL: begin
          run_q  <= wdata_i[0];
          fast_q <= wdata_i[1];
        end
        A_MODE: mode_q <= wdata_i[NUM_CH-1:0];
        A_EDGE: edge_q <= wdata_i[EDGE_W-1:0];
        A_IEN: begin
          ien_ch_q  <= wdata_i[NUM_CH-1:0];
          ien_ovf_q <= wdata_i[7];
        end
        default: ;
      endcase
      if (hi_wr) wr_hold_q <= wdata_i;
    end
  end

  // flags: set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      flag_ch_q <= '0;
    end else begin
      if (wrap)                                          ovf_q <= 1'b1;
      else if ((wr_flags && wdata_i[7]) || (fast_q && cnt_access)) ovf_q <= 1'b0;
      for (int n = 0; n < NUM_CH; n++) begin
        if (ch_event[n])                   flag_ch_q[n] <= 1'b1;
        else if (wr_flags && wdata_i[n])   flag_ch_q[n] <= 1'b0;
      end
    end
  end

  // read mux with low-byte snapshot
  always_comb begin
    rd_mux  = '0;
    rd_snap = '0;
    snap_en = 1'b0;
    case (addr_i)
      A_CTRL:   rd_mux = BYTE_W'({fast_q, run_q});
      A_MODE:   rd_mux = BYTE_W'(mode_q);
      A_EDGE:   rd_mux = BYTE_W'(edge_q);
      A_IEN:    rd_mux = {ien_ovf_q, 7'(ien_ch_q)};
      A_FLAGS:  rd_mux = {ovf_q, 7'(flag_ch_q)};
      A_CNT_HI: begin
        rd_mux  = cnt[CNT_W-1:BYTE_W];
        rd_snap = cnt[BYTE_W-1:0];
        snap_en = 1'b1;
      end
      A_CNT_LO: rd_mux = rd_hold_q;
      default: begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (addr_i[3] && addr_i[2:1] == 2'(n)) begin
            if (!addr_i[0]) begin
              rd_mux  = ch_val[n][CNT_W-1:BYTE_W];
              rd_snap = ch_val[n][BYTE_W-1:0];
              snap_en = 1'b1;
            end else begin
              rd_mux = rd_hold_q;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      rd_hold_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_mux;
      if (snap_en) rd_hold_q <= rd_snap;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = (ovf_q & ien_ovf_q) | (|(flag_ch_q & ien_ch_q));
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        run_q,
  input logic                        fast_q,
  input logic                        cnt_load,
  input logic                        cnt_access,
  input logic [CNT_W-1:0]            cnt,
  input logic                        wrap,
  input logic                        ovf_q,
  input logic [NUM_CH-1:0]           mode_q,
  input logic [NUM_CH-1:0]           cap_hit,
  input logic [NUM_CH-1:0]           cmp_hit,
  input logic [NUM_CH-1:0]           ch_wr,
  input logic [NUM_CH-1:0]           flag_ch_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_val,
  input logic [NUM_CH-1:0]           cmp_o
);
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !cnt_load |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !cnt_load |=> $stable(cnt));

  a_r3_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !cnt_load && (&cnt) |=> ovf_q && cnt == '0);

  a_r5_fast_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q && cnt_access && !wrap |=> !ovf_q);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_hit[n] && !mode_q[n] |=> flag_ch_q[n] && ch_val[n] == $past(cnt));

    a_r8_cap_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_wr[n] && !mode_q[n] && !cap_hit[n] |=> $stable(ch_val[n]));

    a_r9_cmp_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_hit[n] |=> flag_ch_q[n] && cmp_o[n] != $past(cmp_o[n]));
  end
endmodule

bind capcmp_timer capcmp_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_q      (run_q),
  .fast_q     (fast_q),
  .cnt_load   (cnt_load),
  .cnt_access (cnt_access),
  .cnt        (cnt),
  .wrap       (wrap),
  .ovf_q      (ovf_q),
  .mode_q     (mode_q),
  .cap_hit    (cap_hit),
  .cmp_hit    (cmp_hit),
  .ch_wr      (ch_wr),
  .flag_ch_q  (flag_ch_q),
  .ch_val     (ch_val),
  .cmp_o      (cmp_o)
);

// File: tb/capcmp_timer_tb_top.sv
module capcmp_timer_tb_top;
  localparam logic [3:0] T_CTRL = 4'h0, T_MODE = 4'h1, T_EDGE = 4'h2, T_IEN = 4'h3,
                         T_FLAGS = 4'h4, T_CNT = 4'h6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] cap = '0, cmp;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_val [4];

  always #10 clk = ~clk;

  capcmp_timer #(.NUM_CH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a, v[15:8]); wr(a + 4'd1, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h); rd(a + 4'd1, l); v = {h, l};
  endtask

  // each run of n idle cycles between start and stop counts n+2 times
  task automatic run_for(input int n, input logic [7:0] extra);
    wr(T_CTRL, 8'h01 | extra);
    repeat (n) @(negedge clk);
    wr(T_CTRL, extra);
  endtask

  task automatic make_ovf(input logic [7:0] extra);
    wr16(T_CNT, 16'hFFFF);
    run_for(0, extra);
  endtask

  function automatic logic [3:0] ch_addr(input int n);
    return 4'(8 + 2 * n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v, got;
    for (int n = 0; n < 4; n++) exp_val[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      chk($sformatf("R1 reset addr %0h", a), b, 0);
    end
    chk("R1 reset cmp_o", cmp, 0);
    chk("R1 reset irq_o", irq, 0);

    // R2 load and count runs of several lengths
    wr16(T_CNT, 16'h1234);
    rd16(T_CNT, got); chk("R2 load", got, 16'h1234);
    foreach (exp_val[i]) ;
    for (int k = 0; k < 4; k++) begin
      int len;
      len = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 17;
      rd16(T_CNT, v);
      run_for(len, 8'h00);
      rd16(T_CNT, got);
      chk($sformatf("R2 run len %0d", len), got, 32'(16'(v + 16'(len + 2))));
      repeat (4) @(negedge clk);
      rd16(T_CNT, got);
      chk("R2 hold while stopped", got, 32'(16'(v + 16'(len + 2))));
    end

    // R3 wrap boundaries
    wr16(T_CNT, 16'hFFFD); run_for(0, 8'h00);
    rd(T_FLAGS, b); chk("R3 no ovf at FFFF", b, 0);
    wr16(T_CNT, 16'hFFFE); run_for(0, 8'h00);
    rd(T_FLAGS, b); chk("R3 ovf on wrap", b, 8'h80);
    rd16(T_CNT, got); chk("R3 counter wrapped", got, 0);

    // R4 write-one-to-clear
    wr(T_FLAGS, 8'h00); rd(T_FLAGS, b); chk("R4 write zero keeps", b, 8'h80);
    wr(T_FLAGS, 8'h80); rd(T_FLAGS, b); chk("R4 write one clears", b, 8'h00);

    // R5 fast clear
    make_ovf(8'h00);
    rd(T_CNT, b); rd(T_CNT + 4'd1, b);
    rd(T_FLAGS, b); chk("R5 no clear when disabled", b, 8'h80);
    wr(T_CTRL, 8'h02);
    rd(T_CNT + 4'd1, b);
    rd(T_FLAGS, b); chk("R5 read clears", b, 8'h00);
    make_ovf(8'h02);
    rd(T_FLAGS, b); chk("R5 ovf set again", b, 8'h80);
    wr(T_CNT, 8'h00);
    rd(T_FLAGS, b); chk("R5 write clears", b, 8'h00);
    wr(T_CTRL, 8'h00);

    // R7 capture sweep: every channel, every edge code, both directions
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < 4; c++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic hit;
          v = 16'h1000 + 16'(n * 256 + c * 16 + dir);
          wr(T_FLAGS, 8'hFF);
          wr(T_EDGE, 8'(c << (2 * n)));
          wr16(T_CNT, v);
          @(negedge clk); cap[n] = (dir == 0);
          repeat (5) @(negedge clk);
          hit = (dir == 0) ? (c == 1 || c == 3) : (c == 2 || c == 3);
          if (hit) exp_val[n] = v;
          rd16(ch_addr(n), got);
          chk($sformatf("R7 ch%0d code %0d dir %0d value", n, c, dir), got, exp_val[n]);
          rd(T_FLAGS, b);
          chk($sformatf("R7 ch%0d code %0d dir %0d flag", n, c, dir), b, hit ? (1 << n) : 0);
        end
      end
    end

    // R8 capture-mode writes ignored
    wr(T_FLAGS, 8'hFF);
    for (int n = 0; n < 4; n++) begin
      wr16(ch_addr(n), 16'hABCD);
      rd16(ch_addr(n), got); chk($sformatf("R8 ch%0d write ignored", n), got, exp_val[n]);
    end

    // R6 compare mode accepts writes
    wr(T_MODE, 8'h0F);
    wr16(ch_addr(0), 16'h1FF0); wr16(ch_addr(1), 16'h1FF8);
    wr16(ch_addr(2), 16'h2005); wr16(ch_addr(3), 16'h2100);
    rd16(ch_addr(2), got); chk("R6 compare write accepted", got, 16'h2005);

    // R9 compare hits over two runs
    wr(T_FLAGS, 8'hFF);
    wr16(T_CNT, 16'h1FF0);
    run_for(10, 8'h00);
    rd(T_FLAGS, b); chk("R9 flags run 1", b, 8'h03);
    chk("R9 pins run 1", cmp, 4'b0011);
    wr(T_FLAGS, 8'hFF);
    run_for(8, 8'h00);
    rd16(T_CNT, got); chk("R9 counter end", got, 16'h2006);
    rd(T_FLAGS, b); chk("R9 flags run 2", b, 8'h04);
    chk("R9 pins run 2", cmp, 4'b0111);

    // R11 interrupt gating (channel 2 flag pending)
    chk("R11 irq no enable", irq, 0);
    wr(T_IEN, 8'h04); chk("R11 irq ch2 enabled", irq, 1);
    wr(T_IEN, 8'h80); chk("R11 irq ovf only enabled", irq, 0);
    make_ovf(8'h00); chk("R11 irq ovf pending", irq, 1);
    wr(T_FLAGS, 8'h80); chk("R11 irq after ovf clear", irq, 0);

    // R10 byte coherency
    wr(ch_addr(1), 8'h77);
    rd16(ch_addr(1), got); chk("R10 lone high write", got, 16'h1FF8);
    wr(ch_addr(1) + 4'd1, 8'h99);
    rd16(ch_addr(1), got); chk("R10 commit on low write", got, 16'h7799);
    wr16(T_CNT, 16'h12EF);
    rd(T_CNT, b); chk("R10 counter high", b, 8'h12);
    wr16(T_CNT, 16'h3456);
    rd(T_CNT + 4'd1, b); chk("R10 low byte latched", b, 8'hEF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule